// File: doc/BRIEF.md
# Edge-Capturing General-Purpose I/O Port

This block is a parameterised general-purpose I/O port (eight pins by default) driven through a small address/data register interface. Every pin has its own direction control and output data bit. Each input pin is brought into the clock domain through a two-flop synchronizer. Each input pin then feeds one of two paths, chosen per pin: a level path that keeps a sampled copy of the pin, or an edge path that records a transition of the chosen polarity in a sticky status bit.

The sticky edge bits stay set until software clears them by writing 1. Masked by per-pin enables, they drive an interrupt line and a separate wakeup request line. Register writes take effect at the clock edge on which `bus_wr` is high. Reads return data combinationally from `bus_addr`.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset the registers hold: direction (address 0) 0xFF, output data (address 1) 0x00, polarity (address 4) 0xFF, mode (address 5) 0x00, wakeup enable (address 6) 0x00, interrupt enable (address 7) 0x00, edge status (address 3) 0x00. Also after reset `pin_oe` is 0, `irq_o` is 0 and `wake_o` is 0.
- R2: A direction bit of 0 makes that pin an output: `pin_oe` for the pin is 1 and `pin_o` carries the output data bit. Reading the level register (address 2) returns that output data bit for output pins.
- R3: An input pin whose mode bit is 0 (level entry) has its bit in the level register (address 2) follow the pin, through the two-flop synchronizer, within four clock cycles.
- R4: An input pin whose mode bit is 1 (edge entry) leaves its level register bit unchanged. A pin in level mode never sets its edge status bit.
- R5: An input pin in edge mode with polarity bit 0 sets its edge status bit on a rising transition. With polarity bit 1 it sets the bit on a falling transition. A transition of the other sense is ignored.
- R6: An edge status bit stays set until a write to address 3 with a 1 in that bit position clears it. Writing 0 to a bit leaves it unchanged.
- R7: When a new qualifying edge arrives in the same cycle as a clearing write to that bit, the bit remains set.
- R8: `irq_o` is the OR over pins of (edge status AND interrupt enable). `wake_o` is the OR over pins of (edge status AND wakeup enable).
- R9: A pin configured as output (direction bit 0) never sets its edge status bit, even in edge mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Read data for `bus_addr` |
| pin_i | input | NPINS | Pad input values |
| pin_o | output | NPINS | Pad output values |
| pin_oe | output | NPINS | Pad output enables, 1 = drive |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wakeup request |

## Verification
The assertions assume that `bus_addr` and `bus_wdata` are defined whenever `bus_wr` is high. They also assume that pin inputs hold steady between changes long enough to pass the synchronizer. The stimulus meets both conditions by changing bus and pin inputs only on the falling clock edge. It also holds every pin pattern for several cycles before sampling. The one exception is the clear-race test: it deliberately times a clearing write to land on the same edge at which a synchronized transition is detected.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    localparam int unsigned REG_AW = 3;

    typedef enum logic [REG_AW-1:0] {
        RA_DIR  = 3'd0,
        RA_OUT  = 3'd1,
        RA_LVL  = 3'd2,
        RA_EDGE = 3'd3,
        RA_POL  = 3'd4,
        RA_MODE = 3'd5,
        RA_WAKE = 3'd6,
        RA_IRQ  = 3'd7
    } reg_addr_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int unsigned NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_i,
    output logic [NPINS-1:0] sync_o,
    output logic [NPINS-1:0] prev_o
);
    typedef struct packed {
        logic [NPINS-1:0] s1;
        logic [NPINS-1:0] s2;
        logic [NPINS-1:0] s3;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = pin_i;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.s2;
    assign prev_o = st_q.s3;
endmodule

// File: rtl/gpio_edge_sel.sv
module gpio_edge_sel #(
    parameter int unsigned NPINS = 8
) (
    input  logic [NPINS-1:0] cur_i,
    input  logic [NPINS-1:0] prev_i,
    input  logic [NPINS-1:0] neg_i,
    input  logic [NPINS-1:0] arm_i,
    output logic [NPINS-1:0] hit_o
);
    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        logic rise, fall;
        assign rise     = cur_i[g] & ~prev_i[g];
        assign fall     = ~cur_i[g] & prev_i[g];
        assign hit_o[g] = arm_i[g] & (neg_i[g] ? fall : rise);
    end
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
    import gpio_port_pkg::*;
#(
    parameter int unsigned NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [2:0]       bus_addr,
    input  logic [NPINS-1:0] bus_wdata,
    output logic [NPINS-1:0] bus_rdata,
    input  logic [NPINS-1:0] pin_i,
    output logic [NPINS-1:0] pin_o,
    output logic [NPINS-1:0] pin_oe,
    output logic             irq_o,
    output logic             wake_o
);
    localparam logic [NPINS-1:0] ALL_ONES = {NPINS{1'b1}};

    typedef struct packed {
        logic [NPINS-1:0] dir;
        logic [NPINS-1:0] dout;
        logic [NPINS-1:0] lvl;
        logic [NPINS-1:0] edge_st;
        logic [NPINS-1:0] pol;
        logic [NPINS-1:0] mode;
        logic [NPINS-1:0] wake_en;
        logic [NPINS-1:0] irq_en;
    } regs_t;

    regs_t rg_d, rg_q;

    logic [NPINS-1:0] sync_v, prev_v, arm, hit, edge_st;
    reg_addr_e        addr_e;

    assign addr_e = reg_addr_e'(bus_addr);
    assign arm    = rg_q.mode & rg_q.dir;

    gpio_in_sync #(.NPINS(NPINS)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_i),
        .sync_o (sync_v),
        .prev_o (prev_v)
    );

    gpio_edge_sel #(.NPINS(NPINS)) esel_i (
        .cur_i  (sync_v),
        .prev_i (prev_v),
        .neg_i  (rg_q.pol),
        .arm_i  (arm),
        .hit_o  (hit)
    );

    always_comb begin
        logic [NPINS-1:0] lvl_upd;
        logic [NPINS-1:0] clr;
        rg_d    = rg_q;
        clr     = '0;
        lvl_upd = rg_q.dir & ~rg_q.mode;
        rg_d.lvl = (rg_q.lvl & ~lvl_upd) | (sync_v & lvl_upd);
        if (bus_wr) begin
            case (addr_e)
                RA_DIR:  rg_d.dir     = bus_wdata;
                RA_OUT:  rg_d.dout    = bus_wdata;
                RA_EDGE: clr          = bus_wdata;
                RA_POL:  rg_d.pol     = bus_wdata;
                RA_MODE: rg_d.mode    = bus_wdata;
                RA_WAKE: rg_d.wake_en = bus_wdata;
                RA_IRQ:  rg_d.irq_en  = bus_wdata;
                default: ;
            endcase
        end
        rg_d.edge_st = (rg_q.edge_st & ~clr) | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q         <= '0;
            rg_q.dir     <= ALL_ONES;
            rg_q.pol     <= ALL_ONES;
        end else begin
            rg_q <= rg_d;
        end
    end

    always_comb begin
        case (addr_e)
            RA_DIR:  bus_rdata = rg_q.dir;
            RA_OUT:  bus_rdata = rg_q.dout;
            RA_LVL:  bus_rdata = (rg_q.lvl & rg_q.dir) | (rg_q.dout & ~rg_q.dir);
            RA_EDGE: bus_rdata = rg_q.edge_st;
            RA_POL:  bus_rdata = rg_q.pol;
            RA_MODE: bus_rdata = rg_q.mode;
            RA_WAKE: bus_rdata = rg_q.wake_en;
            default: bus_rdata = rg_q.irq_en;
        endcase
    end

    assign edge_st = rg_q.edge_st;
    assign pin_o   = rg_q.dout;
    assign pin_oe  = ~rg_q.dir;
    assign irq_o   = |(rg_q.edge_st & rg_q.irq_en);
    assign wake_o  = |(rg_q.edge_st & rg_q.wake_en);
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
    parameter int unsigned NPINS = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic [2:0]       bus_addr,
    input logic [NPINS-1:0] bus_wdata,
    input logic [NPINS-1:0] pin_o,
    input logic [NPINS-1:0] pin_oe,
    input logic             irq_o,
    input logic             wake_o,
    input logic [NPINS-1:0] edge_st,
    input logic [NPINS-1:0] arm
);
    logic [NPINS-1:0] clr_mask;
    logic             wr_dir, wr_out;

    assign clr_mask = (bus_wr && bus_addr == 3'd3) ? bus_wdata : '0;
    assign wr_dir   = bus_wr && bus_addr == 3'd0;
    assign wr_out   = bus_wr && bus_addr == 3'd1;

    // R2: output enables follow the last direction write
    a_r2_oe_follows: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dir |=> (pin_oe == ~$past(bus_wdata)));

    // R2: driven value only changes through a write
    a_r2_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_out |=> $stable(pin_o));

    // R6: set bits survive unless cleared
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(edge_st) & ~$past(clr_mask) & ~edge_st) == '0));

    // R4 / R9: only armed pins (edge mode, input) can newly set status
    a_r4_armed_only: assert property (@(posedge clk) disable iff (!rst_n)
        ((edge_st & ~$past(edge_st) & ~$past(arm)) == '0));

    // R8: no status means no request
    a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_st == '0) |-> (!irq_o && !wake_o));
endmodule

bind gpio_edge_port gpio_port_chk #(.NPINS(NPINS)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pin_o     (pin_o),
    .pin_oe    (pin_oe),
    .irq_o     (irq_o),
    .wake_o    (wake_o),
    .edge_st   (edge_st),
    .arm       (arm)
);

// File: tb/gpio_edge_port_tb_top.sv
module gpio_edge_port_tb_top;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0;
    logic [2:0]   bus_addr = 3'd0;
    logic [N-1:0] bus_wdata = '0;
    logic [N-1:0] bus_rdata;
    logic [N-1:0] pin_i = '0;
    logic [N-1:0] pin_o, pin_oe;
    logic         irq_o, wake_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gpio_edge_port #(.NPINS(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_i(pin_i),
        .pin_o(pin_o), .pin_oe(pin_oe), .irq_o(irq_o), .wake_o(wake_o)
    );

    typedef struct packed {
        logic       wr;
        logic [2:0] wa;
        logic [7:0] wd;
        logic [7:0] pins;
        logic [2:0] ra;
        logic [7:0] ex;
    } vec_t;

    // Addresses: 0 dir, 1 out, 2 level, 3 edge, 4 pol, 5 mode, 6 wake, 7 irq
    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 3'd5, 8'h0F, 8'h00, 3'd2, 8'h00}, // R3 low nibble edge mode
        '{1'b0, 3'd0, 8'h00, 8'hF0, 3'd2, 8'hF0}, // R3 level pins follow
        '{1'b1, 3'd4, 8'h0A, 8'hF0, 3'd3, 8'h00}, // R5 pol: 1,3 falling
        '{1'b0, 3'd0, 8'h00, 8'hF5, 3'd3, 8'h05}, // R5 rising on 0,2
        '{1'b0, 3'd0, 8'h00, 8'hF0, 3'd3, 8'h05}, // R5 falls ignored on 0,2
        '{1'b0, 3'd0, 8'h00, 8'hFA, 3'd3, 8'h05}, // R5 rises ignored on 1,3
        '{1'b0, 3'd0, 8'h00, 8'hF0, 3'd3, 8'h0F}, // R5 falling on 1,3
        '{1'b0, 3'd0, 8'h00, 8'hF0, 3'd2, 8'hF0}, // R4 edge pins held level
        '{1'b1, 3'd3, 8'h00, 8'hF0, 3'd3, 8'h0F}, // R6 write 0 no effect
        '{1'b1, 3'd3, 8'h03, 8'hF0, 3'd3, 8'h0C}, // R6 w1c
        '{1'b1, 3'd0, 8'h0F, 8'hF0, 3'd2, 8'h00}, // R2 upper outputs read out
        '{1'b1, 3'd1, 8'hA0, 8'hF0, 3'd2, 8'hA0}, // R2 readback of driven
        '{1'b0, 3'd0, 8'h00, 8'h0F, 3'd3, 8'h0D}  // R5 bit0 rise, R4 upper ignored
    };

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [N-1:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] v;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        rd(3'd0, v); chk("R1 dir", v, 8'hFF);
        rd(3'd1, v); chk("R1 out", v, 8'h00);
        rd(3'd3, v); chk("R1 edge", v, 8'h00);
        rd(3'd4, v); chk("R1 pol", v, 8'hFF);
        rd(3'd5, v); chk("R1 mode", v, 8'h00);
        rd(3'd6, v); chk("R1 wake_en", v, 8'h00);
        rd(3'd7, v); chk("R1 irq_en", v, 8'h00);
        chk("R1 pin_oe", pin_oe, 8'h00);
        chk("R1 irq/wake", {6'd0, irq_o, wake_o}, 8'h00);

        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            pin_i = VEC[k].pins;
            if (VEC[k].wr) wr(VEC[k].wa, VEC[k].wd);
            idle(5);
            rd(VEC[k].ra, v);
            chk($sformatf("vector %0d (R2-R6)", k), v, VEC[k].ex);
        end
        chk("R2 pin_oe", pin_oe, 8'hF0);
        chk("R2 pin_o", pin_o, 8'hA0);

        // R8 interrupt / wakeup masking, status = 0x0D
        wr(3'd7, 8'h04); #1 chk("R8 irq on", {7'd0, irq_o}, 8'h01);
        wr(3'd7, 8'h02); #1 chk("R8 irq masked", {7'd0, irq_o}, 8'h00);
        chk("R8 wake off", {7'd0, wake_o}, 8'h00);
        wr(3'd6, 8'h01); #1 chk("R8 wake on", {7'd0, wake_o}, 8'h01);

        // R7 clear racing a new edge on bit0 (rising mode)
        @(negedge clk); pin_i = 8'h0E;
        idle(5);
        @(negedge clk); pin_i = 8'h0F;
        @(posedge clk); @(posedge clk);
        wr(3'd3, 8'h01);
        idle(2);
        rd(3'd3, v); chk("R7 edge wins", v, 8'h0D);
        wr(3'd3, 8'h01);
        rd(3'd3, v); chk("R6 plain clear", v, 8'h0C);
        chk("R8 wake cleared", {7'd0, wake_o}, 8'h00);

        // R9 edge-mode pin set as output ignores its pad
        wr(3'd0, 8'h0E);
        @(negedge clk); pin_i = 8'h0E;
        idle(5);
        @(negedge clk); pin_i = 8'h0F;
        idle(5);
        rd(3'd3, v); chk("R9 output no capture", v, 8'h0C);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule